// File: doc/BRIEF.md
# Video Timing Generator with Border Regions

This block produces the horizontal and vertical timing for a raster display whose visible area is framed by border bands. It has four bands on the left, right, top and bottom. On every axis a position counter passes through six consecutive regions. The sync pulse comes first. The back porch follows, then the leading border and then the active display. The trailing border and the front porch close the line or frame, and the counter then wraps. Software programs the start of each region as a 12-bit position. Each 32-bit timing word carries two positions. There are three such words per axis and one sync control word.

The control word holds a global run bit, a polarity bit for each sync and a hold bit for each sync. A hold bit forces that sync to its idle level. Changes to the control word act on the next pixel. A new set of timing positions waits for the end of the current frame before it is used, so no frame mixes two geometries. The outputs are hsync, vsync, a display-enable, a border-enable and the pixel and line positions. All of them are registered and change on the same clock edge.

Top module: `bordered_video_timing`

## Requirements
- R1: Seven 32-bit words sit at addresses 0 to 6. Addresses 0, 1 and 2 are horizontal words 1 to 3, addresses 3, 4 and 5 are vertical words 1 to 3, and address 6 is the sync control word. Each timing word keeps one 12-bit position in bits 11:0 and another in bits 27:16. Every bit written to any word, including unused bits, reads back unchanged. After reset the timing words read 0 and the control word reads 0x0000000F.
- R2: While running, the horizontal position counts from 0 to total−1 and wraps. The line position advances by one on each horizontal wrap and wraps after total−1. The pixelX and lineY outputs report the position that the other outputs of the same cycle describe. Word 1 of each axis holds the total in bits 11:0.
- R3: When control bit 31 (run) is 0, pixelX and lineY read 0, dispEn and borderEn are 0, and both syncs are at their idle level. When run is set, the first reported position is (0,0).
- R4: A sync is active while its position is below the back porch start, which word 1 of that axis holds in bits 27:16. Control bit 1 sets the hsync polarity and bit 3 sets the vsync polarity: 1 gives an active-high pulse, 0 gives an active-low pulse.
- R5: Control bit 0 holds hsync at its idle level and control bit 2 holds vsync at its idle level, whatever the position.
- R6: dispEn is 1 exactly when both positions are at or after the display start and before the trailing border start. Word 2 holds the display start in bits 27:16 and word 3 holds the trailing border start in bits 11:0.
- R7: borderEn is 1 exactly when both positions are at or after the leading border start (word 2, bits 11:0) and before the front porch start (word 3, bits 27:16), and dispEn is 0.
- R8: A timing word written mid-frame has no effect until the frame in progress ends. Its new values apply from position (0,0) of the next frame. A write to the control word applies from the next reported position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 32 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 32 | Register read data (combinational) |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| dispEn | output | 1 | Active display region |
| borderEn | output | 1 | Border region |
| pixelX | output | 12 | Reported horizontal position |
| lineY | output | 12 | Reported vertical position |

## Verification
On every cycle the assertions check several properties. dispEn and borderEn are never high together. The horizontal counter stays below its total. The line counter moves only on a horizontal wrap. A stopped generator clears both counters. A hold bit forces the idle sync level. The active timing never changes while the counters are away from (0,0), so a frame is never torn. The bench scenarios cover the rest. Across whole frames they compare every output against positions computed arithmetically, for two geometries and for every polarity and hold setting. They also show that the old geometry stays in use for the rest of a frame after a mid-frame rewrite, that unused register bits read back unchanged, and that a restart begins at (0,0).

// File: rtl/vtg_border_pkg.sv
package vtg_border_pkg;
  localparam int FIELD_W        = 12;
  localparam int WORD_W         = 32;
  localparam int LO_LSB         = 0;
  localparam int HI_LSB         = 16;
  localparam int NUM_AXES       = 2;
  localparam int WORDS_PER_AXIS = 3;
  localparam int CTRL_ADDR      = NUM_AXES * WORDS_PER_AXIS;
  localparam int NUM_WORDS      = CTRL_ADDR + 1;
  localparam int RUN_BIT        = 31;
  localparam int HHOLD_BIT      = 0;
  localparam int HPOL_BIT       = 1;
  localparam int VHOLD_BIT      = 2;
  localparam int VPOL_BIT       = 3;
  localparam logic [WORD_W-1:0] CTRL_RESET = 32'h0000_000F;

  typedef struct packed {
    logic [FIELD_W-1:0] total;
    logic [FIELD_W-1:0] syncEnd;
    logic [FIELD_W-1:0] leadStart;
    logic [FIELD_W-1:0] dispStart;
    logic [FIELD_W-1:0] trailStart;
    logic [FIELD_W-1:0] fpStart;
  } vtg_axis_t;

  typedef struct packed {
    logic run;
    logic load;
    logic hHold;
    logic vHold;
    logic hPol;
    logic vPol;
  } vtg_strobe_t;
endpackage

// File: rtl/vtg_axis_decode.sv
module vtg_axis_decode
  import vtg_border_pkg::*;
(
  input  logic [FIELD_W-1:0] cnt,
  input  logic [FIELD_W-1:0] syncEnd,
  input  logic [FIELD_W-1:0] leadStart,
  input  logic [FIELD_W-1:0] dispStart,
  input  logic [FIELD_W-1:0] trailStart,
  input  logic [FIELD_W-1:0] fpStart,
  output logic               inSync,
  output logic               inDisp,
  output logic               inWin
);
  // region membership along one axis
  assign inSync = cnt < syncEnd;
  assign inDisp = (cnt >= dispStart) && (cnt < trailStart);
  assign inWin  = (cnt >= leadStart) && (cnt < fpStart);
endmodule

// File: rtl/vtg_ctrl.sv
module vtg_ctrl
  import vtg_border_pkg::*;
#(
  parameter int ADDR_W = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData,
  input  logic              frameEnd,
  output vtg_axis_t         shadowCfg [NUM_AXES],
  output vtg_strobe_t       strb
);
  logic [WORD_W-1:0] words [NUM_WORDS];
  logic [WORD_W-1:0] ctrlWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_WORDS; i++)
        words[i] <= (i == CTRL_ADDR) ? CTRL_RESET : '0;
    end else if (wrEn && (wrAddr < ADDR_W'(NUM_WORDS))) begin
      words[wrAddr] <= wrData;
    end
  end

  assign rdData   = (rdAddr < ADDR_W'(NUM_WORDS)) ? words[rdAddr] : '0;
  assign ctrlWord = words[CTRL_ADDR];

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
    localparam int BASE = a * WORDS_PER_AXIS;
    assign shadowCfg[a].total      = words[BASE][LO_LSB +: FIELD_W];
    assign shadowCfg[a].syncEnd    = words[BASE][HI_LSB +: FIELD_W];
    assign shadowCfg[a].leadStart  = words[BASE+1][LO_LSB +: FIELD_W];
    assign shadowCfg[a].dispStart  = words[BASE+1][HI_LSB +: FIELD_W];
    assign shadowCfg[a].trailStart = words[BASE+2][LO_LSB +: FIELD_W];
    assign shadowCfg[a].fpStart    = words[BASE+2][HI_LSB +: FIELD_W];
  end

  always_comb begin
    strb.run   = ctrlWord[RUN_BIT];
    strb.hHold = ctrlWord[HHOLD_BIT];
    strb.vHold = ctrlWord[VHOLD_BIT];
    strb.hPol  = ctrlWord[HPOL_BIT];
    strb.vPol  = ctrlWord[VPOL_BIT];
    // a stopped generator tracks the shadow; a running one waits for frame end
    strb.load  = !ctrlWord[RUN_BIT] || frameEnd;
  end
endmodule

// File: rtl/vtg_datapath.sv
module vtg_datapath
  import vtg_border_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  vtg_strobe_t        strb,
  input  vtg_axis_t          shadowCfg [NUM_AXES],
  output logic               frameEnd,
  output logic               hsync,
  output logic               vsync,
  output logic               dispEn,
  output logic               borderEn,
  output logic [FIELD_W-1:0] pixelX,
  output logic [FIELD_W-1:0] lineY
);
  vtg_axis_t          actCfg  [NUM_AXES];
  logic [FIELD_W-1:0] cnt     [NUM_AXES];
  logic [FIELD_W-1:0] lastPos [NUM_AXES];
  logic [NUM_AXES-1:0] inSync, inDisp, inWin;
  logic hAct, vAct, deNext, beNext;

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
    assign lastPos[a] = actCfg[a].total - 1'b1;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) actCfg[a] <= '0;
      else if (strb.load) actCfg[a] <= shadowCfg[a];
    end

    vtg_axis_decode dec_i (
      .cnt        (cnt[a]),
      .syncEnd    (actCfg[a].syncEnd),
      .leadStart  (actCfg[a].leadStart),
      .dispStart  (actCfg[a].dispStart),
      .trailStart (actCfg[a].trailStart),
      .fpStart    (actCfg[a].fpStart),
      .inSync     (inSync[a]),
      .inDisp     (inDisp[a]),
      .inWin      (inWin[a])
    );
  end

  assign frameEnd = strb.run && (cnt[0] == lastPos[0]) && (cnt[1] == lastPos[1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt[0] <= '0;
      cnt[1] <= '0;
    end else if (!strb.run) begin
      cnt[0] <= '0;
      cnt[1] <= '0;
    end else if (cnt[0] == lastPos[0]) begin
      cnt[0] <= '0;
      cnt[1] <= (cnt[1] == lastPos[1]) ? '0 : cnt[1] + 1'b1;
    end else begin
      cnt[0] <= cnt[0] + 1'b1;
    end
  end

  always_comb begin
    hAct   = strb.run && !strb.hHold && inSync[0];
    vAct   = strb.run && !strb.vHold && inSync[1];
    deNext = strb.run && (&inDisp);
    beNext = strb.run && (&inWin) && !(&inDisp);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsync    <= 1'b0;
      vsync    <= 1'b0;
      dispEn   <= 1'b0;
      borderEn <= 1'b0;
      pixelX   <= '0;
      lineY    <= '0;
    end else begin
      hsync    <= strb.hPol ? hAct : !hAct;
      vsync    <= strb.vPol ? vAct : !vAct;
      dispEn   <= deNext;
      borderEn <= beNext;
      pixelX   <= strb.run ? cnt[0] : '0;
      lineY    <= strb.run ? cnt[1] : '0;
    end
  end

  assert_de_be_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(dispEn && borderEn));

  assert_h_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && actCfg[0].total != '0) |-> (cnt[0] < actCfg[0].total));

  assert_v_steps_on_wrap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && cnt[0] != lastPos[0]) |=> $stable(cnt[1]));

  assert_stop_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> (cnt[0] == '0 && cnt[1] == '0));

  assert_no_tear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cnt[0] != '0 || cnt[1] != '0) |-> ($stable(actCfg[0]) && $stable(actCfg[1])));

  assert_hhold_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.hHold |=> (hsync == !$past(strb.hPol)));

  assert_vhold_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.vHold |=> (vsync == !$past(strb.vPol)));
endmodule

// File: rtl/bordered_video_timing.sv
module bordered_video_timing
  import vtg_border_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [2:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic [2:0]  rdAddr,
  output logic [31:0] rdData,
  output logic        hsync,
  output logic        vsync,
  output logic        dispEn,
  output logic        borderEn,
  output logic [11:0] pixelX,
  output logic [11:0] lineY
);
  vtg_axis_t   shadowCfg [NUM_AXES];
  vtg_strobe_t strb;
  logic        frameEnd;

  vtg_ctrl #(.ADDR_W(3)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .frameEnd  (frameEnd),
    .shadowCfg (shadowCfg),
    .strb      (strb)
  );

  vtg_datapath dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .shadowCfg (shadowCfg),
    .frameEnd  (frameEnd),
    .hsync     (hsync),
    .vsync     (vsync),
    .dispEn    (dispEn),
    .borderEn  (borderEn),
    .pixelX    (pixelX),
    .lineY     (lineY)
  );
endmodule

// File: tb/bordered_video_timing_tb_top.sv
module bordered_video_timing_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        hsync, vsync, dispEn, borderEn;
  logic [11:0] pixelX, lineY;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] sh [6];
  logic [31:0] cu [6];
  logic [31:0] ctrlM = 32'h0000_000F;
  bit valid = 0;
  bit startPending = 0;
  int prevX = 0, prevY = 0;
  string posTag = "R2";

  always #4 clk = ~clk;

  bordered_video_timing dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .hsync(hsync), .vsync(vsync),
    .dispEn(dispEn), .borderEn(borderEn), .pixelX(pixelX), .lineY(lineY)
  );

  function automatic int fld(logic [31:0] w, bit hi);
    return hi ? int'(w[27:16]) : int'(w[11:0]);
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic writeReg(int a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    valid = 0;
    if (a < 6) sh[a] = d;
    else begin
      if (!ctrlM[31] && d[31]) startPending = 1;
      ctrlM = d;
    end
  endtask

  task automatic readChk(int a, logic [31:0] exp);
    rdAddr = 3'(a);
    #1;
    chk(rdData == exp, "R1", $sformatf("readback word %0d", a), int'(rdData), int'(exp));
  endtask

  task automatic monitor(int n);
    for (int k = 0; k < n; k++) begin
      int ex, ey, hT, vT;
      bit run, hA, vA, eh, ev, hD, vD, hW, vW, eDe, eBe;
      string sTagH, sTagV;
      @(negedge clk);
      run = ctrlM[31];
      hT = fld(cu[0], 0); vT = fld(cu[3], 0);
      if (!run) begin
        for (int i = 0; i < 6; i++) cu[i] = sh[i];
        ex = 0; ey = 0;
      end else if (startPending) begin
        ex = 0; ey = 0; startPending = 0;
      end else if (valid) begin
        ex = prevX + 1; ey = prevY;
        if (prevX == hT - 1) begin
          ex = 0;
          ey = (prevY == vT - 1) ? 0 : prevY + 1;
        end
      end else begin
        ex = int'(pixelX); ey = int'(lineY);
      end
      chk(int'(pixelX) == ex, posTag, "pixelX", int'(pixelX), ex);
      chk(int'(lineY) == ey, posTag, "lineY", int'(lineY), ey);
      if (run && ex == 0 && ey == 0)
        for (int i = 0; i < 6; i++) cu[i] = sh[i];
      hA = run && !ctrlM[0] && (ex < fld(cu[0], 1));
      vA = run && !ctrlM[2] && (ey < fld(cu[3], 1));
      eh = ctrlM[1] ? hA : !hA;
      ev = ctrlM[3] ? vA : !vA;
      hD = ex >= fld(cu[1], 1) && ex < fld(cu[2], 0);
      vD = ey >= fld(cu[4], 1) && ey < fld(cu[5], 0);
      hW = ex >= fld(cu[1], 0) && ex < fld(cu[2], 1);
      vW = ey >= fld(cu[4], 0) && ey < fld(cu[5], 1);
      eDe = run && hD && vD;
      eBe = run && hW && vW && !eDe;
      sTagH = !run ? "R3" : (ctrlM[0] ? "R5" : "R4");
      sTagV = !run ? "R3" : (ctrlM[2] ? "R5" : "R4");
      chk(hsync == eh, sTagH, "hsync", int'(hsync), int'(eh));
      chk(vsync == ev, sTagV, "vsync", int'(vsync), int'(ev));
      chk(dispEn == eDe, run ? "R6" : "R3", "dispEn", int'(dispEn), int'(eDe));
      chk(borderEn == eBe, run ? "R7" : "R3", "borderEn", int'(borderEn), int'(eBe));
      prevX = ex; prevY = ey; valid = run;
    end
  endtask

  task automatic waitLine(int y);
    for (int k = 0; k < 2000; k++) begin
      monitor(1);
      if (prevX == 0 && prevY == y) break;
    end
  endtask

  initial begin
    logic [31:0] cfgA [6];
    logic [31:0] cfgB [6];
    cfgA = '{32'h0002_0014, 32'h0006_0004, 32'h0010_000E,
             32'h0001_000C, 32'h0004_0002, 32'h000A_0008};
    cfgB = '{32'h0003_0010, 32'h0005_0004, 32'h000D_000B,
             32'h0002_000A, 32'h0004_0003, 32'h0008_0007};
    for (int i = 0; i < 6; i++) begin sh[i] = '0; cu[i] = '0; end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R3 reset state and R1 reset values
    chk(pixelX == 0, "R3", "reset pixelX", int'(pixelX), 0);
    chk(lineY == 0, "R3", "reset lineY", int'(lineY), 0);
    chk(hsync == 0, "R3", "reset hsync", int'(hsync), 0);
    chk(dispEn == 0 && borderEn == 0, "R3", "reset enables", int'({dispEn, borderEn}), 0);
    readChk(6, 32'h0000_000F);
    readChk(2, 32'h0);
    // R1 all bits preserved, including unused ones
    for (int i = 0; i < 6; i++) begin
      writeReg(i, cfgA[i] | 32'hA000_5000);
      readChk(i, cfgA[i] | 32'hA000_5000);
    end
    monitor(10);
    // R2 R4 R6 R7 with geometry A, active-high syncs
    writeReg(6, 32'h8000_000A);
    readChk(6, 32'h8000_000A);
    monitor(600);
    // R8 mid-frame rewrite: old geometry must finish the frame
    waitLine(5);
    for (int i = 0; i < 6; i++) writeReg(i, cfgB[i]);
    posTag = "R8";
    monitor(500);
    posTag = "R2";
    // R4 active-low syncs
    writeReg(6, 32'h8000_0000);
    monitor(300);
    // R5 holds with high and low polarity
    writeReg(6, 32'h8000_000F);
    monitor(200);
    writeReg(6, 32'h8000_0005);
    monitor(200);
    // R3 stop and restart from (0,0)
    writeReg(6, 32'h0000_0005);
    monitor(20);
    writeReg(6, 32'h8000_000A);
    posTag = "R3";
    monitor(1);
    posTag = "R2";
    monitor(200);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule